// File: doc/BRIEF.md
# Branch Target Buffer with Next-PC Select

This block sits in the fetch stage and supplies the address of the next instruction to fetch. In the same cycle it reads one entry of a direct-mapped table, chosen by the current fetch PC. Each entry holds a valid flag, the full PC of a branch, the branch's last taken target and a two-bit confidence counter. The block compares the stored branch PC with the fetch PC. When they match and the counter leans taken, the stored target becomes the next PC. In every other case the next PC is the fetch PC plus four.

A resolution port from the back end reports each branch it has resolved: its PC, its actual target and whether it was taken. A taken branch that has no entry claims the entry at its index. A branch that already has an entry trains that entry's counter and, when taken, refreshes the stored target. Writes take effect at the clock edge, so a lookup in the same cycle still sees the old contents.

Each entry's counter is a four-state machine, `ctr_e`, with states STRONG_NT (0), WEAK_NT (1), WEAK_T (2) and STRONG_T (3). The transitions are named as follows:
- **step-up**: a taken outcome moves the counter one state toward STRONG_T and holds at STRONG_T.
- **step-down**: a not-taken outcome moves it one state toward STRONG_NT and holds at STRONG_NT.
- **seed**: a new entry enters at WEAK_T.

The next-PC select uses a two-state decision, `sel_e`:
- **SEL_SEQ**: the next PC is the sequential address.
- **SEL_TGT**: the next PC is the stored target.

Top module: `btb_next_pc`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports `pred_hit`=0 and `next_pc`=`fetch_pc`+4.
- R2: When the indexed entry is invalid, or its stored branch PC differs from `fetch_pc` in any bit (the low two bits included), the same cycle gives `pred_hit`=0, `pred_taken`=0 and `next_pc`=`fetch_pc`+4.
- R3: When the indexed entry is valid, its stored PC equals `fetch_pc` and its counter is 2 or 3, the same cycle gives `pred_hit`=1, `pred_taken`=1 and `next_pc` equal to the stored target.
- R4: When the entry matches and its counter is 0 or 1, the same cycle gives `pred_hit`=1, `pred_taken`=0 and `next_pc`=`fetch_pc`+4.
- R5: A resolved taken branch that misses writes the entry at its index, replacing any other branch held there. The written entry is valid, stores `upd_pc` and `upd_target`, and has its counter at 2 (weakly taken).
- R6: A resolved branch that hits moves its counter up by one on taken and down by one on not-taken. The counter holds at 3 when stepping up and at 0 when stepping down. The encoding is 0 = strongly not-taken, 1 = weakly not-taken, 2 = weakly taken, 3 = strongly taken.
- R7: A resolved not-taken branch that misses changes no entry.
- R8: The table index is `fetch_pc[IDX_W+1:2]` (and `upd_pc[IDX_W+1:2]` for updates). Entries at different indices are independent, and two PCs that share an index but differ in other bits do not hit each other's entry.
- R9: A taken hit replaces the stored target with `upd_target`. A not-taken hit keeps the stored target.
- R10: An update becomes visible to lookups only from the cycle after the clock edge that accepts it. A lookup of the same index in the same cycle sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all valid flags |
| fetch_pc | input | PC_W | Current fetch address |
| next_pc | output | PC_W | Address to fetch next |
| pred_hit | output | 1 | Indexed entry matches fetch_pc |
| pred_taken | output | 1 | Hit and counter leans taken |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_target | input | PC_W | Actual target of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |

## Verification
The lookup outputs depend only on `fetch_pc` and the stored table, with no register between them. The bench therefore drives `fetch_pc` at a falling edge and samples the outputs a short time later, within the same half cycle. A resolution update is driven at a falling edge and is committed by the next rising edge. The first lookup that may observe it is made after that edge. A dedicated check drives an update and a lookup of the same index together and expects the old result before the edge and the new result after it. Expected results come from a table kept in the bench that follows the allocation and counter rules. This covers counter saturation at both ends, aliasing at one index, and a sweep over every index.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Two-bit confidence counter; bit 1 set means "predict taken".
    typedef enum logic [1:0] {
        STRONG_NT = 2'd0,
        WEAK_NT   = 2'd1,
        WEAK_T    = 2'd2,
        STRONG_T  = 2'd3
    } ctr_e;

    // Next-PC choice made by the lookup path.
    typedef enum logic {
        SEL_SEQ = 1'b0,
        SEL_TGT = 1'b1
    } sel_e;

    localparam logic [1:0] SEED_CTR = 2'd2;

endpackage

// File: rtl/btb_ctr_step.sv
module btb_ctr_step
    import btb_pkg::*;
(
    input  ctr_e cur,
    input  logic taken,
    output ctr_e nxt
);

    always_comb begin
        nxt = cur;
        unique case (cur)
            STRONG_NT: nxt = taken ? WEAK_NT  : STRONG_NT;
            WEAK_NT:   nxt = taken ? WEAK_T   : STRONG_NT;
            WEAK_T:    nxt = taken ? STRONG_T : WEAK_NT;
            STRONG_T:  nxt = taken ? STRONG_T : WEAK_T;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [PC_W-1:0]  rd_tag,
    output logic [PC_W-1:0]  rd_target,
    output ctr_e             rd_ctr,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic [PC_W-1:0]  upd_target,
    input  logic             upd_taken
);

    logic [DEPTH-1:0] valid_q;
    logic [PC_W-1:0]  tag_q [DEPTH];
    logic [PC_W-1:0]  tgt_q [DEPTH];
    ctr_e             ctr_q [DEPTH];

    logic [IDX_W-1:0] upd_idx;
    logic             upd_hit;
    logic             wr_en;
    ctr_e             stepped;
    ctr_e             new_ctr;
    logic [DEPTH-1:0] we;

    assign upd_idx = upd_pc[IDX_W+1:2];
    assign upd_hit = valid_q[upd_idx] && (tag_q[upd_idx] == upd_pc);
    assign wr_en   = upd_valid && (upd_hit || upd_taken);

    btb_ctr_step u_step (
        .cur   (ctr_q[upd_idx]),
        .taken (upd_taken),
        .nxt   (stepped)
    );

    assign new_ctr = upd_hit ? stepped : ctr_e'(SEED_CTR);

    for (genvar e = 0; e < DEPTH; e++) begin : g_we
        assign we[e] = wr_en && (upd_idx == IDX_W'(e));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int e = 0; e < DEPTH; e++) begin
                ctr_q[e] <= STRONG_NT;
            end
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (we[e]) begin
                    valid_q[e] <= 1'b1;
                    ctr_q[e]   <= new_ctr;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (we[e]) begin
                tag_q[e] <= upd_pc;
                if (upd_taken) begin
                    tgt_q[e] <= upd_target;
                end
            end
        end
    end

    assign rd_valid  = valid_q[rd_idx];
    assign rd_tag    = tag_q[rd_idx];
    assign rd_target = tgt_q[rd_idx];
    assign rd_ctr    = ctr_q[rd_idx];

    // R1: table comes out of reset empty
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid_q == '0));

    // R5: a taken miss leaves a valid, weakly-taken entry with its PC
    assert_alloc_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(upd_valid && upd_taken && !upd_hit) |->
            (valid_q[$past(upd_idx)] && ctr_q[$past(upd_idx)] == WEAK_T
             && tag_q[$past(upd_idx)] == $past(upd_pc)));

    // R6: a taken hit on a saturated entry stays saturated
    assert_sat_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(upd_valid && upd_hit && upd_taken && ctr_q[upd_idx] == STRONG_T)
            |-> (ctr_q[$past(upd_idx)] == STRONG_T));

    // R7: a not-taken miss leaves every valid flag untouched
    assert_nt_miss_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(upd_valid && !upd_taken && !upd_hit) |-> $stable(valid_q));

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            rd_valid,
    input  logic [PC_W-1:0] rd_tag,
    input  logic [PC_W-1:0] rd_target,
    input  ctr_e            rd_ctr,
    output logic [PC_W-1:0] next_pc,
    output logic            pred_hit,
    output logic            pred_taken
);

    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    sel_e sel;
    logic match;
    logic leans_taken;

    assign match = rd_valid && (rd_tag == fetch_pc);

    always_comb begin
        leans_taken = 1'b0;
        unique case (rd_ctr)
            STRONG_NT, WEAK_NT: leans_taken = 1'b0;
            WEAK_T, STRONG_T:   leans_taken = 1'b1;
            default:            leans_taken = 1'b0;
        endcase
    end

    assign sel = (match && leans_taken) ? SEL_TGT : SEL_SEQ;

    always_comb begin
        pred_hit   = match;
        pred_taken = 1'b0;
        next_pc    = fetch_pc + STEP;
        unique case (sel)
            SEL_SEQ: begin
                pred_taken = 1'b0;
                next_pc    = fetch_pc + STEP;
            end
            SEL_TGT: begin
                pred_taken = 1'b1;
                next_pc    = rd_target;
            end
            default: ;
        endcase
    end

    // R2: no hit always means sequential fetch
    assert_miss_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> (!pred_taken && next_pc == fetch_pc + STEP));

    // R3: taken prediction steers fetch to the stored target
    assert_taken_tgt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> (pred_hit && next_pc == rd_target));

endmodule

// File: rtl/btb_next_pc.sv
module btb_next_pc
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic [PC_W-1:0] next_pc,
    output logic            pred_hit,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_taken
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0] rd_idx;
    logic             rd_valid;
    logic [PC_W-1:0]  rd_tag;
    logic [PC_W-1:0]  rd_target;
    ctr_e             rd_ctr;

    assign rd_idx = fetch_pc[IDX_W+1:2];

    btb_store #(.PC_W(PC_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (rd_idx),
        .rd_valid   (rd_valid),
        .rd_tag     (rd_tag),
        .rd_target  (rd_target),
        .rd_ctr     (rd_ctr),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_target (upd_target),
        .upd_taken  (upd_taken)
    );

    btb_lookup #(.PC_W(PC_W)) u_lookup (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_pc   (fetch_pc),
        .rd_valid   (rd_valid),
        .rd_tag     (rd_tag),
        .rd_target  (rd_target),
        .rd_ctr     (rd_ctr),
        .next_pc    (next_pc),
        .pred_hit   (pred_hit),
        .pred_taken (pred_taken)
    );

    // R4: a hit never moves fetch off the sequential path unless taken
    assert_hit_nt_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_hit && !pred_taken) |-> (next_pc == fetch_pc + PC_W'(4)));

endmodule

// File: tb/btb_next_pc_tb.sv
module btb_next_pc_tb;

    localparam int PC_W   = 32;
    localparam int DEPTH  = 16;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam time CLK_P = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic [PC_W-1:0] next_pc;
    logic            pred_hit;
    logic            pred_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic [PC_W-1:0] upd_target = '0;
    logic            upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;

    logic            m_v   [DEPTH];
    logic [PC_W-1:0] m_tag [DEPTH];
    logic [PC_W-1:0] m_tgt [DEPTH];
    int              m_ctr [DEPTH];

    always #(CLK_P/2) clk = ~clk;

    btb_next_pc #(.PC_W(PC_W), .DEPTH(DEPTH)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_pc   (fetch_pc),
        .next_pc    (next_pc),
        .pred_hit   (pred_hit),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_target (upd_target),
        .upd_taken  (upd_taken)
    );

    function automatic int idx_of(logic [PC_W-1:0] pc);
        return int'(pc[IDX_W+1:2]);
    endfunction

    task automatic model_update(logic [PC_W-1:0] pc, logic [PC_W-1:0] tgt, logic tk);
        int i = idx_of(pc);
        if (m_v[i] && m_tag[i] == pc) begin
            if (tk) begin
                m_ctr[i] = (m_ctr[i] == 3) ? 3 : m_ctr[i] + 1;
                m_tgt[i] = tgt;
            end else begin
                m_ctr[i] = (m_ctr[i] == 0) ? 0 : m_ctr[i] - 1;
            end
        end else if (tk) begin
            m_v[i] = 1'b1; m_tag[i] = pc; m_tgt[i] = tgt; m_ctr[i] = 2;
        end
    endtask

    task automatic check_now(string req, logic [PC_W-1:0] pc);
        int i = idx_of(pc);
        logic eh = m_v[i] && m_tag[i] == pc;
        logic et = eh && m_ctr[i] >= 2;
        logic [PC_W-1:0] en = et ? m_tgt[i] : pc + 4;
        checks++;
        if (pred_hit !== eh || pred_taken !== et || next_pc !== en) begin
            errors++;
            $display("FAIL %s pc=%h actual hit=%b tk=%b next=%h expected hit=%b tk=%b next=%h",
                     req, pc, pred_hit, pred_taken, next_pc, eh, et, en);
        end
    endtask

    task automatic look(string req, logic [PC_W-1:0] pc);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        check_now(req, pc);
    endtask

    task automatic resolve(logic [PC_W-1:0] pc, logic [PC_W-1:0] tgt, logic tk);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_target = tgt; upd_taken = tk;
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        model_update(pc, tgt, tk);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset, every index
        for (int i = 0; i < DEPTH; i++) look("R1", 32'h0000_2000 + i * 4);

        // R10: update and lookup of the same PC in one cycle
        @(negedge clk);
        fetch_pc = 32'h0000_1040;
        upd_valid = 1'b1; upd_pc = 32'h0000_1040; upd_target = 32'h0000_9000; upd_taken = 1'b1;
        #1;
        check_now("R10", 32'h0000_1040);
        @(posedge clk);
        #1;
        upd_valid = 1'b0;
        model_update(32'h0000_1040, 32'h0000_9000, 1'b1);
        check_now("R10", 32'h0000_1040);
        // R5: allocated entry is weakly taken and steers to target
        look("R5", 32'h0000_1040);
        // R2: low bits differ -> full-PC tag misses
        look("R2", 32'h0000_1041);

        // R6/R4: walk counter down through saturation
        resolve(32'h0000_1040, 32'h0, 1'b0); look("R4", 32'h0000_1040);
        resolve(32'h0000_1040, 32'h0, 1'b0); look("R6", 32'h0000_1040);
        resolve(32'h0000_1040, 32'h0, 1'b0); look("R6", 32'h0000_1040);
        resolve(32'h0000_1040, 32'h0000_A000, 1'b1); look("R6", 32'h0000_1040);
        // R9: taken hit refreshes target
        resolve(32'h0000_1040, 32'h0000_B000, 1'b1); look("R9", 32'h0000_1040);
        resolve(32'h0000_1040, 32'h0000_B100, 1'b1); look("R6", 32'h0000_1040);
        resolve(32'h0000_1040, 32'h0000_B200, 1'b1); look("R6", 32'h0000_1040);
        // R6: step down from saturated high is still taken; R9 target kept
        resolve(32'h0000_1040, 32'h0000_CCCC, 1'b0); look("R9", 32'h0000_1040);

        // R7: not-taken miss allocates nothing
        resolve(32'h0000_3004, 32'h0000_7000, 1'b0); look("R7", 32'h0000_3004);
        // R7: not-taken miss on an aliasing PC keeps the resident entry
        resolve(32'h0000_1080, 32'h0000_7000, 1'b0); look("R7", 32'h0000_1040);

        // R8/R3: sweep all indices with arithmetic targets
        for (int i = 0; i < DEPTH; i++)
            resolve(32'h0000_4000 + i * 4, 32'h0008_0000 + i * 16, 1'b1);
        for (int i = 0; i < DEPTH; i++) look("R3", 32'h0000_4000 + i * 4);
        // R8: same index, different upper bits -> miss
        for (int i = 0; i < DEPTH; i++) look("R8", 32'h0000_4000 + DEPTH * 4 + i * 4);

        // R5: taken miss replaces the aliasing resident
        resolve(32'h0000_4000 + DEPTH * 4, 32'h000F_0000, 1'b1);
        look("R5", 32'h0000_4000 + DEPTH * 4);
        look("R8", 32'h0000_4000);

        // R1: reset again empties the table
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
        for (int i = 0; i < DEPTH; i++) look("R1", 32'h0000_4000 + i * 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule